// File: doc/BRIEF.md
# Shared-Bus Request/Grant/Busy Arbiter

This block arbitrates a shared bus among a parameterized set of requesters. It uses three active-low control lines: a request from each requester, a grant to each requester, and one shared busy line. A central arbiter looks at the pending requests and grants exactly one requester. A grant alone does not give the bus to that requester. The granted requester must also see the shared busy line negated. Only then does it drive busy low, and on the same clock edge it withdraws its request. It keeps busy asserted for the whole transfer and drops it when its local client reports completion. That release ends the arbitration.

Each requester is a small state machine: idle, requesting, owning. Its client logic drives it with a "want the bus" level and a "transfer done" pulse. The busy line is formed as the wired-AND of every requester's active-low busy output. The arbiter frees a grant only after it sees the holder withdraw its request while the bus is busy. It then re-evaluates the pending requests on the next cycle. Requesters other than the owner can therefore be granted while a transfer is in progress, and they wait for the bus to go idle.

Top module: `busarb_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, every request and grant line is high (negated), the busy line is high and no requester owns the bus.
- R2: An idle requester whose `want_i` bit is high at a clock edge drives its request line low after that edge. The request stays low until it takes ownership, whatever `want_i` does in between.
- R3: With no grant outstanding, the arbiter drives low, one edge after it sees them, the grant of the lowest-indexed requester whose request is low. At most one grant line is low at any time.
- R4: A grant stays low until an edge at which the busy line is low and the granted requester's request line is high. It goes high after that edge, and any new grant appears no earlier than the following edge.
- R5: A granted requester takes ownership only at an edge where its grant is low and the busy line is high. It then drives busy low and its request high on that same edge.
- R6: At most one requester owns the bus (drives busy low) at any time. `owner_o` bit i is high exactly when requester i owns the bus.
- R7: A `done_i` pulse to the owning requester negates its busy output after the next edge, and the requester returns to idle. A `done_i` pulse to a requester that is not owning has no effect.
- R8: `bbusy_n_o` is low exactly when at least one requester drives busy low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| want_i | input | NUM_REQ | Per-requester client level asking for the bus |
| done_i | input | NUM_REQ | Per-requester client pulse ending the transfer |
| breq_n_o | output | NUM_REQ | Active-low bus request lines, one per requester |
| bgnt_n_o | output | NUM_REQ | Active-low bus grant lines, one per requester |
| bbusy_n_o | output | 1 | Active-low shared busy line (wired-AND) |
| owner_o | output | NUM_REQ | One-hot (or zero) indication of the current bus owner |

## Verification
The assertions assume the requesters are the only drivers of the request and busy lines. Under that assumption a requester drops its request only when it takes ownership, and the arbiter's release condition holds. The client inputs are otherwise unconstrained: `want_i` and `done_i` may arrive in any state. The stimulus deliberately drops `want_i` while a request is pending and pulses `done_i` to requesters that are waiting but not owning. The bench changes inputs only on falling edges, so every input is stable across the rising edge that samples it.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    AG_IDLE = 2'd0,
    AG_REQ  = 2'd1,
    AG_OWN  = 2'd2
  } agent_st_e;

endpackage

// File: rtl/busarb_prio.sv
// Lowest-index-first one-hot selector over a request vector.
module busarb_prio #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] pend_i,
  output logic [WIDTH-1:0] pick_o
);

  logic [WIDTH-1:0] lower_pending;

  assign lower_pending[0] = 1'b0;
  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign lower_pending[i] = lower_pending[i-1] | pend_i[i-1];
  end

  assign pick_o = pend_i & ~lower_pending;

  always_comb begin
    assert ($onehot0(pick_o)) else $error("prio pick not one-hot (R3)");
  end

endmodule

// File: rtl/busarb_grant.sv
// Central arbiter: registered active-low grants, held until ownership is seen.
module busarb_grant #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] breq_n_i,
  input  logic               bbusy_n_i,
  output logic [NUM_REQ-1:0] bgnt_n_o
);

  logic [NUM_REQ-1:0] gnt_q;
  logic [NUM_REQ-1:0] pending;
  logic [NUM_REQ-1:0] pick;
  logic               held;
  logic               release_now;

  assign pending = ~breq_n_i;
  assign held    = |gnt_q;
  // Holder has withdrawn its request while the bus is busy: it took ownership.
  assign release_now = held && !bbusy_n_i && |(gnt_q & breq_n_i);

  busarb_prio #(.WIDTH(NUM_REQ)) u_prio (
    .pend_i (pending),
    .pick_o (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
    end else if (held) begin
      if (release_now) gnt_q <= '0;
    end else if (|pending) begin
      gnt_q <= pick;
    end
  end

  assign bgnt_n_o = ~gnt_q;

  p_one_grant_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bgnt_n_o));

  p_grant_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (held && !(!bbusy_n_i && |(~bgnt_n_o & breq_n_i))) |=> $stable(bgnt_n_o));

  p_gap_after_release_r4: assert property (@(posedge clk) disable iff (rst)
    release_now |=> (&bgnt_n_o));

endmodule

// File: rtl/busarb_agent.sv
// Requester-side handshake: request, wait for grant and idle bus, own, release.
module busarb_agent (
  input  logic clk,
  input  logic rst,
  input  logic want_i,
  input  logic done_i,
  input  logic gnt_n_i,
  input  logic bbusy_n_i,
  output logic breq_n_o,
  output logic busy_n_o
);
  import busarb_pkg::*;

  agent_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= AG_IDLE;
      breq_n_o <= 1'b1;
      busy_n_o <= 1'b1;
    end else begin
      case (st_q)
        AG_IDLE: begin
          if (want_i) begin
            st_q     <= AG_REQ;
            breq_n_o <= 1'b0;
          end
        end
        AG_REQ: begin
          if (!gnt_n_i && bbusy_n_i) begin
            st_q     <= AG_OWN;
            breq_n_o <= 1'b1;
            busy_n_o <= 1'b0;
          end
        end
        AG_OWN: begin
          if (done_i) begin
            st_q     <= AG_IDLE;
            busy_n_o <= 1'b1;
          end
        end
        default: begin
          st_q     <= AG_IDLE;
          breq_n_o <= 1'b1;
          busy_n_o <= 1'b1;
        end
      endcase
    end
  end

  p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
    (!breq_n_o && busy_n_o) |=> (!breq_n_o || !busy_n_o));

  p_take_needs_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n_o) |-> ($past(bbusy_n_i) && !$past(gnt_n_i)));

  p_req_drops_with_busy_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n_o) |-> $rose(breq_n_o));

  p_release_on_done_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy_n_o && done_i) |=> busy_n_o);

endmodule

// File: rtl/busarb_top.sv
module busarb_top #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] want_i,
  input  logic [NUM_REQ-1:0] done_i,
  output logic [NUM_REQ-1:0] breq_n_o,
  output logic [NUM_REQ-1:0] bgnt_n_o,
  output logic               bbusy_n_o,
  output logic [NUM_REQ-1:0] owner_o
);

  logic [NUM_REQ-1:0] busy_n_vec;

  busarb_grant #(.NUM_REQ(NUM_REQ)) u_grant (
    .clk       (clk),
    .rst       (rst),
    .breq_n_i  (breq_n_o),
    .bbusy_n_i (bbusy_n_o),
    .bgnt_n_o  (bgnt_n_o)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_agent
    busarb_agent u_agent (
      .clk       (clk),
      .rst       (rst),
      .want_i    (want_i[i]),
      .done_i    (done_i[i]),
      .gnt_n_i   (bgnt_n_o[i]),
      .bbusy_n_i (bbusy_n_o),
      .breq_n_o  (breq_n_o[i]),
      .busy_n_o  (busy_n_vec[i])
    );
  end

  // Wired-AND of the active-low busy outputs.
  assign bbusy_n_o = &busy_n_vec;
  assign owner_o   = ~busy_n_vec;

  p_single_owner_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(owner_o));

  p_busy_iff_owner_r8: assert property (@(posedge clk) disable iff (rst)
    (bbusy_n_o == 1'b0) == (|owner_o));

endmodule

// File: tb/busarb_top_test.sv
`timescale 1ns/1ps
module busarb_top_test;

  localparam int N     = 4;
  localparam int STEPS = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] want = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] breq_n, bgnt_n, owner;
  logic         bbusy_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  busarb_top #(.NUM_REQ(N)) uut (
    .clk       (clk),
    .rst       (rst),
    .want_i    (want),
    .done_i    (done),
    .breq_n_o  (breq_n),
    .bgnt_n_o  (bgnt_n),
    .bbusy_n_o (bbusy_n),
    .owner_o   (owner)
  );

  // {want, done, exp_owner, exp_breq_n, exp_bgnt_n, exp_bbusy_n}; outputs after the edge.
  localparam logic [20:0] VEC [STEPS] = '{
    {4'b0110, 4'b0000, 4'b0000, 4'b1001, 4'b1111, 1'b1}, // 0 R2: 1,2 request
    {4'b0000, 4'b0000, 4'b0000, 4'b1001, 4'b1101, 1'b1}, // 1 R3: grant 1, R2 want dropped
    {4'b0000, 4'b0000, 4'b0010, 4'b1011, 4'b1101, 1'b0}, // 2 R5: 1 owns
    {4'b0001, 4'b0000, 4'b0010, 4'b1010, 4'b1111, 1'b0}, // 3 R4: release grant
    {4'b0000, 4'b0000, 4'b0010, 4'b1010, 4'b1110, 1'b0}, // 4 R3: grant 0 over 2
    {4'b0000, 4'b0001, 4'b0010, 4'b1010, 4'b1110, 1'b0}, // 5 R7/R5: done to waiter ignored
    {4'b0000, 4'b0010, 4'b0000, 4'b1010, 4'b1110, 1'b1}, // 6 R7: 1 releases
    {4'b0000, 4'b0000, 4'b0001, 4'b1011, 4'b1110, 1'b0}, // 7 R5: 0 owns
    {4'b0000, 4'b0000, 4'b0001, 4'b1011, 4'b1111, 1'b0}, // 8 R4
    {4'b0000, 4'b0000, 4'b0001, 4'b1011, 4'b1011, 1'b0}, // 9 R3: grant 2
    {4'b0000, 4'b0001, 4'b0000, 4'b1011, 4'b1011, 1'b1}, // 10 R7
    {4'b0001, 4'b0000, 4'b0100, 4'b1110, 4'b1011, 1'b0}, // 11 R5 + R2
    {4'b0000, 4'b0000, 4'b0100, 4'b1110, 4'b1111, 1'b0}, // 12 R4
    {4'b0000, 4'b0000, 4'b0100, 4'b1110, 4'b1110, 1'b0}, // 13 R3
    {4'b0000, 4'b0100, 4'b0000, 4'b1110, 4'b1110, 1'b1}, // 14 R7
    {4'b0000, 4'b0000, 4'b0001, 4'b1111, 4'b1110, 1'b0}, // 15 R5
    {4'b0000, 4'b0000, 4'b0001, 4'b1111, 4'b1111, 1'b0}, // 16 R4
    {4'b0000, 4'b0001, 4'b0000, 4'b1111, 4'b1111, 1'b1}  // 17 R7
  };

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] w, input logic [N-1:0] d);
    @(negedge clk);
    want = w;
    done = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check_idle(input string tag);
    check(tag, "breq_n", breq_n, '1);
    check(tag, "bgnt_n", bgnt_n, '1);
    check(tag, "bbusy_n", {{(N-1){1'b0}}, bbusy_n}, 4'b0001);
    check(tag, "owner", owner, '0);
  endtask

  initial begin
    #(8 * 5000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_idle("R1");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_idle("R1");

    for (int k = 0; k < STEPS; k++) begin
      step(VEC[k][20:17], VEC[k][16:13]);
      check("R6", $sformatf("owner step %0d", k), owner, VEC[k][12:9]);
      check("R2", $sformatf("breq_n step %0d", k), breq_n, VEC[k][8:5]);
      check("R3", $sformatf("bgnt_n step %0d", k), bgnt_n, VEC[k][4:1]);
      check("R8", $sformatf("bbusy_n step %0d", k),
            {{(N-1){1'b0}}, bbusy_n}, {3'b000, VEC[k][0]});
    end

    // R3: all four request together, index 0 wins.
    step(4'b1111, 4'b0000);
    check("R2", "all request", breq_n, 4'b0000);
    step(4'b0000, 4'b0000);
    check("R3", "lowest index wins", bgnt_n, 4'b1110);
    step(4'b0000, 4'b0000);
    check("R5", "winner owns", owner, 4'b0001);
    check("R5", "winner request dropped", breq_n, 4'b0001);

    // R1: reset in the middle of a transfer returns everything to idle.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_idle("R1");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_idle("R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule